// File: doc/BRIEF.md
# Serial Byte Receiver with Request-Driven FIFO

This block is a receive-only synchronous serial slave. A host drives three wires into it: a bit clock, a framing strobe and a data line. The block samples all three with its own faster system clock and finds edges on the synchronized copies. It shifts each data bit in on a rising edge of the bit clock, most significant bit first. Every eight bits make one byte, which goes into a 256-entry byte queue.

An active-low request output tells the host when the queue is running low, so the host can send a burst and then wait. A framing edge taken while the bit clock is low restarts byte alignment. It abandons any bits already collected. On-chip logic drains the queue through a valid/ready pop port. A fill count comes out beside it. A byte that completes while the queue is full is dropped, and a sticky overflow flag records the loss.

Top module: `ssrx_top`

## Requirements
- R1: Bits are taken on each rising edge of `ser_clk_i` from `ser_data_i`. The first bit of a byte is bit 7 of the stored value and the eighth bit is bit 0.
- R2: A rising edge of `ser_frame_i` while `ser_clk_i` is low clears the bit position. Bits already gathered are discarded, and the next rising edge of `ser_clk_i` carries bit 7 of a new byte.
- R3: A rising edge of `ser_frame_i` while `ser_clk_i` is high is ignored, and the byte in progress continues.
- R4: Completed bytes are queued in arrival order, up to 256 entries. `fill_o` gives the number held, from 0 to 256.
- R5: `req_n_o` is low while `fill_o` is below 64 and high while it is 64 or more.
- R6: `pop_valid_o` is high exactly when the queue holds a byte, and `pop_data_o` then shows the oldest byte. One byte leaves on each clock edge where `pop_valid_o` and `pop_ready_i` are both high. While valid is high and ready is low, valid and data hold steady. Ready with an empty queue has no effect.
- R7: A byte that completes while `fill_o` is 256, with no pop on that edge, is discarded. `overflow_o` then goes high and stays high until reset.
- R8: A byte that completes on the same edge as a pop from a full queue is accepted. `fill_o` stays at 256 and the new byte joins the tail.
- R9: After reset the queue is empty, `pop_valid_o`, `overflow_o` and `req_n_o` are low, and the first bit-clock rising edge starts a byte without any framing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Host bit clock (asynchronous) |
| ser_frame_i | input | 1 | Host framing strobe; rising edge with bit clock low realigns |
| ser_data_i | input | 1 | Host serial data, changed on bit-clock falling edges |
| req_n_o | output | 1 | Low when the host should send more data |
| pop_valid_o | output | 1 | Queue holds a byte |
| pop_ready_i | input | 1 | Consumer takes the head byte this edge |
| pop_data_o | output | 8 | Oldest queued byte |
| fill_o | output | 9 | Bytes held, 0 to 256 |
| overflow_o | output | 1 | Sticky: a byte was dropped on a full queue |

## Verification
A byte can finish assembling on the very edge where the consumer pops the head. When the queue is full, the outcome depends on handling the two together. The bench fills the queue to 256 entries. It then counts system cycles from the final bit-clock rising edge of the next byte through the two synchronizer stages and the assembler register. It raises `pop_ready_i` for exactly the edge on which that byte is pushed. The result is judged in three ways: the fill stays at 256, the overflow flag does not change because of it, and a full drain returns the new byte last, in order.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int BYTE_BITS = 8;
  typedef logic [BYTE_BITS-1:0] rx_byte_t;
endpackage

// File: rtl/ssrx_sync.sv
// Multi-flop synchronizer per input line with rising-edge detection
module ssrx_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], async_i[i]};
    end
    assign level_o[i] = pipe[STAGES-1];
    assign rise_o[i]  = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/ssrx_assembler.sv
// Shifts bits in MSB first and emits a one-cycle pulse per completed byte
module ssrx_assembler
  import ssrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_rise_i,
  input  logic     bit_val_i,
  input  logic     realign_i,
  output logic     byte_vld_o,
  output rx_byte_t byte_o
);
  localparam int CNTW = $clog2(BYTE_BITS);
  localparam logic [CNTW-1:0] LAST = CNTW'(BYTE_BITS - 1);

  logic [CNTW-1:0] pos_q;
  rx_byte_t        shift_q;
  rx_byte_t        shift_nx;

  assign shift_nx = {shift_q[BYTE_BITS-2:0], bit_val_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      shift_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (realign_i) begin
        pos_q   <= '0;
        shift_q <= '0;
      end else if (bit_rise_i) begin
        shift_q <= shift_nx;
        pos_q   <= pos_q + 1'b1;
        if (pos_q == LAST) begin
          byte_vld_o <= 1'b1;
          byte_o     <= shift_nx;
        end
      end
    end
  end
endmodule

// File: rtl/ssrx_fifo.sv
// Byte queue; a push on a full queue is taken only if a pop happens on the same edge
module ssrx_fifo
  import ssrx_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  rx_byte_t      push_data_i,
  input  logic          pop_ready_i,
  output logic          pop_valid_o,
  output rx_byte_t      pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  rx_byte_t        mem [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic            full, pop_fire, push_ok;

  assign full        = (count_o == CW'(DEPTH));
  assign pop_valid_o = (count_o != '0);
  assign pop_fire    = pop_valid_o & pop_ready_i;
  assign push_ok     = push_i & (~full | pop_fire);
  assign drop_o      = push_i & full & ~pop_fire;
  assign pop_data_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_fire) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_o <= count_o + CW'(push_ok) - CW'(pop_fire);
    end
  end
endmodule

// File: rtl/ssrx_top.sv
module ssrx_top
  import ssrx_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int LOW_MARK    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_clk_i,
  input  logic                         ser_frame_i,
  input  logic                         ser_data_i,
  output logic                         req_n_o,
  output logic                         pop_valid_o,
  input  logic                         pop_ready_i,
  output logic [BYTE_BITS-1:0]         pop_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   fill_o,
  output logic                         overflow_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int L_CLK = 0, L_FRM = 1, L_DAT = 2;

  logic [2:0] lvl, rise;
  logic       byte_vld, drop, realign;
  rx_byte_t   byte_val;

  ssrx_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_data_i, ser_frame_i, ser_clk_i}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  // framing edge counts only while the synchronized bit clock is low
  assign realign = rise[L_FRM] & ~lvl[L_CLK];

  ssrx_assembler u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_rise_i (rise[L_CLK]),
    .bit_val_i  (lvl[L_DAT]),
    .realign_i  (realign),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  ssrx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (byte_vld),
    .push_data_i (byte_val),
    .pop_ready_i (pop_ready_i),
    .pop_valid_o (pop_valid_o),
    .pop_data_o  (pop_data_o),
    .count_o     (fill_o),
    .drop_o      (drop)
  );

  assign req_n_o = (fill_o >= CW'(LOW_MARK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    overflow_o <= 1'b0;
    else if (drop) overflow_o <= 1'b1;
  end
endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pop_valid_o,
  input logic          pop_ready_i,
  input logic [7:0]    pop_data_o,
  input logic [CW-1:0] fill_o,
  input logic          overflow_o
);
  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CW'(DEPTH));
  // R6
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o && !pop_ready_i |=> pop_valid_o && $stable(pop_data_o));
  // R6
  pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o && pop_ready_i |=> fill_o <= $past(fill_o));
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid_o |=> fill_o <= CW'(1));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(fill_o) == CW'(DEPTH));
endmodule

bind ssrx_top ssrx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pop_valid_o (pop_valid_o),
  .pop_ready_i (pop_ready_i),
  .pop_data_o  (pop_data_o),
  .fill_o      (fill_o),
  .overflow_o  (overflow_o)
);

// File: tb/tb_ssrx_top.sv
module tb_ssrx_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;
  localparam int LOW   = 64;
  localparam int HALF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_frame = 1'b0, ser_data = 1'b0;
  logic       req_n, pop_valid, pop_ready = 1'b0, overflow;
  logic [7:0] pop_data;
  logic [8:0] fill;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_ovf = 0;
  logic [7:0] q[$];

  always #(CLK_P/2) clk = ~clk;

  ssrx_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_frame_i(ser_frame),
    .ser_data_i(ser_data), .req_n_o(req_n), .pop_valid_o(pop_valid),
    .pop_ready_i(pop_ready), .pop_data_o(pop_data), .fill_o(fill),
    .overflow_o(overflow)
  );

  function automatic bit exp_req_n(int n);
    return n >= LOW;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_bit(bit b, bit frame_while_high = 0);
    @(negedge clk) ser_data = b;
    repeat (HALF-1) @(negedge clk);
    ser_clk = 1'b1;
    if (frame_while_high) ser_frame = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    ser_frame = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk) ser_frame = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_frame = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic model_push(logic [7:0] b);
    if (q.size() < DEPTH) q.push_back(b);
    else m_ovf = 1'b1;
  endtask

  // pop_last: pop the head on the exact edge the new byte is pushed
  task automatic send_byte(logic [7:0] b, bit pop_last = 0);
    for (int i = 7; i >= 1; i--) ser_bit(b[i]);
    if (!pop_last) ser_bit(b[0]);
    else begin
      @(negedge clk) ser_data = b[0];
      repeat (HALF-1) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      check(pop_valid == 1'b1, "R8", pop_valid, 1);
      check(pop_data == q[0], "R8", pop_data, q[0]);
      void'(q.pop_front());
      pop_ready = 1'b1;
      @(negedge clk) pop_ready = 1'b0;
      ser_clk = 1'b0;
    end
    model_push(b);
    repeat (8) @(negedge clk);
  endtask

  task automatic pop_one(string req);
    @(negedge clk);
    check(pop_valid == 1'b1, req, pop_valid, 1);
    check(pop_data == q[0], req, pop_data, q[0]);
    void'(q.pop_front());
    pop_ready = 1'b1;
    @(negedge clk) pop_ready = 1'b0;
  endtask

  task automatic check_state(string req);
    @(negedge clk);
    check(fill == q.size(), req, fill, q.size());
    check(req_n == exp_req_n(q.size()), "R5", req_n, exp_req_n(q.size()));
    check(pop_valid == (q.size() != 0), "R6", pop_valid, q.size() != 0);
    check(overflow == m_ovf, "R7", overflow, m_ovf);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    // R9 reset state
    check(fill == 0, "R9", fill, 0);
    check(pop_valid == 0, "R9", pop_valid, 0);
    check(req_n == 0, "R9", req_n, 0);
    check(overflow == 0, "R9", overflow, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 first byte framed without sync
    send_byte(8'hC3);
    check_state("R9");
    pop_one("R9");

    // R1 bit order
    do_sync();
    send_byte(8'h80); send_byte(8'h01); send_byte(8'hA5);
    check_state("R1");
    pop_one("R1"); pop_one("R1"); pop_one("R1");

    // R6 ready on empty queue
    @(negedge clk) pop_ready = 1'b1;
    repeat (3) @(negedge clk);
    pop_ready = 1'b0;
    check(fill == 0, "R6", fill, 0);
    send_byte(8'h5A);
    pop_one("R6");

    // R2 partial byte abandoned by realign
    do_sync();
    ser_bit(1); ser_bit(1); ser_bit(1);
    do_sync();
    send_byte(8'h3C);
    check_state("R2");
    pop_one("R2");

    // R3 frame edge while bit clock high ignored: 0x96 = 1001_0110
    ser_bit(1); ser_bit(0); ser_bit(0, 1);
    ser_bit(1); ser_bit(0); ser_bit(1); ser_bit(1); ser_bit(0);
    model_push(8'h96);
    repeat (8) @(negedge clk);
    check_state("R3");
    pop_one("R3");

    // R4 random bursts and drains
    for (int r = 0; r < 6; r++) begin
      int n = $urandom_range(1, 20);
      for (int k = 0; k < n; k++) send_byte(8'($urandom));
      check_state("R4");
      begin
        int d = $urandom_range(0, q.size());
        for (int k = 0; k < d; k++) pop_one("R4");
      end
    end
    while (q.size() > 0) pop_one("R4");

    // R5 threshold
    while (q.size() < LOW - 1) send_byte(8'($urandom));
    check_state("R5");
    send_byte(8'($urandom));
    check_state("R5");
    pop_one("R5");
    check_state("R5");

    // R7 fill and overflow
    while (q.size() < DEPTH) send_byte(8'($urandom));
    check_state("R4");
    send_byte(8'hEE);
    check_state("R7");

    // R8 push coinciding with pop on a full queue
    send_byte(8'h77, 1);
    check_state("R8");
    while (q.size() > 0) pop_one("R8");
    check_state("R7");

    // R9 reset clears sticky flag
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_ovf = 0;
    check(overflow == 0, "R9", overflow, 0);
    rst_n = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule